// File: doc/BRIEF.md
# Split-Bus Pixel Assembler with Resynchronization

This block sits on the device side of a parallel display-driver host port that runs with a 9-bit data bus. The host moves every 18-bit quantity, whether an instruction or an RGB666 pixel, as two 9-bit bus cycles. The upper half goes first and the lower half second. The block samples the active-low write and read strobes through a synchronizer into the system clock. It uses one shared upper/lower phase to assemble written halves into 18-bit words. It serves 18-bit read data back as two halves in the same order.

A slip of one half-word puts every later word out of alignment. The host repairs this in-band by writing an all-zero instruction four times in a row. On the fourth such write the phase is forced back to upper, so the next bus cycle starts a fresh word. The host is expected to send this pattern once after reset, before its first instruction. Sending it again later is harmless. Assembled instruction words that belong to a zero run are not reported.

Top module: `split_bus_assembler`

## Requirements
- R1: After reset, word_valid is low, db_out is zero, the zero-run count is zero and the phase is upper, so the first write is taken as an upper half.
- R2: A write in upper phase is held. The following write in lower phase completes a word with the held half in bits 17:9 and the new half in bits 8:0. word_is_data equals the rs level of the completing write, where rs high means pixel data and rs low means instruction.
- R3: word_valid is high for exactly one clock cycle, starting at the third rising clk edge at or after the wr_n rise.
- R4: On a falling rd_n, db_out takes rd_word bits 17:9 when the phase is upper and bits 8:0 when it is lower. The change appears at the third rising clk edge after the fall, and db_out holds its value at all other times.
- R5: The rising edge of rd_n advances the same phase that writes use. A write that follows a single read is therefore taken as a lower half.
- R6: An instruction write of zero data (rs low, db_in 0) that is the fourth in an unbroken run of such writes forces the phase to upper and produces no word, whatever the phase was before.
- R7: The zero-run count is cleared by any instruction write with nonzero data and by any data write (rs high). It saturates at four. Reads leave it unchanged.
- R8: An instruction word completed by a zero instruction write that continues a zero run of length one or more is not reported: word_valid stays low.
- R9: Repeating the zero pattern, for example eight zero writes in a row, leaves the block aligned: the next two data writes form a correct pixel.
- R10: word_valid never rises for a write taken as an upper half, nor for any read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_n | input | 1 | Active-low write strobe; the half is captured after its rise |
| rd_n | input | 1 | Active-low read strobe |
| rs | input | 1 | Register select: 0 instruction, 1 pixel data |
| db_in | input | 9 | Host-to-device half-word bus |
| rd_word | input | 18 | 18-bit word to be returned on reads |
| word_out | output | 18 | Assembled word |
| word_valid | output | 1 | One-cycle pulse marking word_out as new |
| word_is_data | output | 1 | Register select of the completed word |
| db_out | output | 9 | Device-to-host half-word bus |

## Verification
The assertions assume that wr_n and rd_n are never low together. They assume that db_in, rs and rd_word stay steady from the strobe's falling edge until several clocks after its rise. They also assume that each strobe stays low and high long enough for the synchronizer to see both levels. The stimulus follows these rules. Every bus cycle holds its strobe low for two clocks and high for at least five, and it leaves data and register select unchanged for that whole span. Reads and writes are issued one at a time and never overlap.

// File: rtl/split_bus_pkg.sv
package split_bus_pkg;
   typedef enum logic {
      PH_UPPER = 1'b0,
      PH_LOWER = 1'b1
   } half_phase_e;
endpackage

// File: rtl/bus_strobe_sync.sv
module bus_strobe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_n,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              last;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("bus_strobe_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '1;
         last  <= 1'b1;
      end else begin
         chain <= {chain[STAGES-2:0], strobe_n};
         last  <= chain[STAGES-1];
      end
   end

   assign rise = chain[STAGES-1] & ~last;
   assign fall = ~chain[STAGES-1] & last;
endmodule

// File: rtl/zero_run_tracker.sv
module zero_run_tracker #(
   parameter int RUN_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_evt,
   input  logic is_zero,
   output logic sync_hit,
   output logic in_run
);
   localparam int CW = $clog2(RUN_LEN + 1);
   logic [CW-1:0] cnt;

   generate
      if (RUN_LEN < 2) begin : g_bad_run
         $error("zero_run_tracker: RUN_LEN must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (wr_evt) begin
         if (!is_zero)                 cnt <= '0;
         else if (cnt != CW'(RUN_LEN)) cnt <= cnt + 1'b1;
      end
   end

   assign sync_hit = wr_evt && is_zero && (cnt == CW'(RUN_LEN - 1));
   assign in_run   = (cnt != '0);

   // R7: a breaking write empties the run
   p_clear_on_break_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_evt && !is_zero) |=> (cnt == '0));
   // R7: count never passes its ceiling
   p_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(RUN_LEN));
endmodule

// File: rtl/half_phase_assembler.sv
module half_phase_assembler
   import split_bus_pkg::*;
#(
   parameter int HALF_W = 9
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_evt,
   input  logic                rd_fall,
   input  logic                rd_rise,
   input  logic                sync_hit,
   input  logic                suppress,
   input  logic                rs,
   input  logic [HALF_W-1:0]   db_in,
   input  logic [2*HALF_W-1:0] rd_word,
   output logic [2*HALF_W-1:0] word_out,
   output logic                word_valid,
   output logic                word_is_data,
   output logic [HALF_W-1:0]   db_out,
   output half_phase_e         phase
);
   localparam int WORD_W = 2 * HALF_W;
   logic [HALF_W-1:0] hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase        <= PH_UPPER;
         hold         <= '0;
         word_out     <= '0;
         word_valid   <= 1'b0;
         word_is_data <= 1'b0;
         db_out       <= '0;
      end else begin
         word_valid <= 1'b0;
         if (wr_evt) begin
            if (sync_hit) begin
               phase <= PH_UPPER;
            end else if (phase == PH_UPPER) begin
               hold  <= db_in;
               phase <= PH_LOWER;
            end else begin
               word_out     <= {hold, db_in};
               word_is_data <= rs;
               word_valid   <= !suppress;
               phase        <= PH_UPPER;
            end
         end else if (rd_rise) begin
            phase <= (phase == PH_UPPER) ? PH_LOWER : PH_UPPER;
         end
         if (rd_fall) begin
            db_out <= (phase == PH_UPPER) ? rd_word[WORD_W-1:HALF_W]
                                          : rd_word[HALF_W-1:0];
         end
      end
   end

   // R3: the valid flag is a single-cycle pulse
   p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid);
   // R10: an upper-half write or a read never yields a word
   p_upper_no_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_evt && phase == PH_UPPER) || rd_rise || rd_fall) |=> !word_valid);
   // R4: the read bus only moves on a read fall
   p_dbout_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_fall |=> $stable(db_out));
endmodule

// File: rtl/split_bus_assembler.sv
module split_bus_assembler
   import split_bus_pkg::*;
#(
   parameter int HALF_W      = 9,
   parameter int SYNC_STAGES = 2,
   parameter int RUN_LEN     = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_n,
   input  logic                rd_n,
   input  logic                rs,
   input  logic [HALF_W-1:0]   db_in,
   input  logic [2*HALF_W-1:0] rd_word,
   output logic [2*HALF_W-1:0] word_out,
   output logic                word_valid,
   output logic                word_is_data,
   output logic [HALF_W-1:0]   db_out
);
   logic        wr_rise, wr_fall_unused, rd_rise, rd_fall;
   logic        is_zero, sync_hit, in_run, suppress;
   half_phase_e phase;

   generate
      if (HALF_W < 1) begin : g_bad_width
         $error("split_bus_assembler: HALF_W must be positive");
      end
   endgenerate

   bus_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
      .clk(clk), .rst_n(rst_n), .strobe_n(wr_n),
      .rise(wr_rise), .fall(wr_fall_unused));

   bus_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
      .clk(clk), .rst_n(rst_n), .strobe_n(rd_n),
      .rise(rd_rise), .fall(rd_fall));

   assign is_zero  = !rs && (db_in == '0);
   assign suppress = is_zero && in_run;

   zero_run_tracker #(.RUN_LEN(RUN_LEN)) u_zero_run (
      .clk(clk), .rst_n(rst_n), .wr_evt(wr_rise), .is_zero(is_zero),
      .sync_hit(sync_hit), .in_run(in_run));

   half_phase_assembler #(.HALF_W(HALF_W)) u_assemble (
      .clk(clk), .rst_n(rst_n), .wr_evt(wr_rise), .rd_fall(rd_fall),
      .rd_rise(rd_rise), .sync_hit(sync_hit), .suppress(suppress),
      .rs(rs), .db_in(db_in), .rd_word(rd_word), .word_out(word_out),
      .word_valid(word_valid), .word_is_data(word_is_data),
      .db_out(db_out), .phase(phase));

   // R6: completing a zero run leaves the phase at upper
   p_sync_forces_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sync_hit |=> (phase == PH_UPPER));
   // R6: the synchronizing write itself never yields a word
   p_sync_no_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sync_hit |=> !word_valid);
   // R8: a zero instruction write inside a run is not reported
   p_run_suppress_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_rise && suppress) |=> !word_valid);
endmodule

// File: tb/split_bus_assembler_bench.sv
module split_bus_assembler_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_n = 1'b1, rd_n = 1'b1, rs = 1'b0;
   logic [8:0]  db_in = '0;
   logic [17:0] rd_word = '0;
   logic [17:0] word_out;
   logic        word_valid, word_is_data;
   logic [8:0]  db_out;

   always #5 clk = ~clk;

   split_bus_assembler u_split_bus_assembler (
      .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rs(rs),
      .db_in(db_in), .rd_word(rd_word), .word_out(word_out),
      .word_valid(word_valid), .word_is_data(word_is_data), .db_out(db_out));

   int    checks = 0, fails = 0, cyc = 0;
   bit    checking = 0, done = 0;
   string cur_req = "R1";

   // reference model state
   int          m_phase = 0;     // 0 upper, 1 lower
   int          m_run = 0;
   logic [8:0]  m_hold = '0;
   logic [18:0] q_word[$];       // {is_data, word}
   int          q_due[$];
   logic [8:0]  m_db = '0, m_db_next = '0;
   int          m_db_due = -1;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (checking) begin
         if (m_db_due == cyc) m_db = m_db_next;
         if (q_due.size() > 0 && q_due[0] == cyc) begin
            check(cur_req, {31'd0, word_valid}, 32'd1, "word_valid");
            check(cur_req, {14'd0, word_out}, {14'd0, q_word[0][17:0]}, "word_out");
            check(cur_req, {31'd0, word_is_data}, {31'd0, q_word[0][18]}, "word_is_data");
            void'(q_due.pop_front());
            void'(q_word.pop_front());
         end else begin
            check(cur_req, {31'd0, word_valid}, 32'd0, "word_valid idle");
         end
         check(cur_req, {23'd0, db_out}, {23'd0, m_db}, "db_out");
      end
   end

   task automatic bus_write(input logic r, input logic [8:0] d);
      bit zero;
      int prev;
      @(negedge clk);
      rs = r; db_in = d; wr_n = 1'b0;
      repeat (2) @(negedge clk);
      wr_n = 1'b1;
      zero = !r && (d == 9'd0);
      prev = m_run;
      m_run = zero ? ((m_run < 4) ? m_run + 1 : 4) : 0;
      if (zero && prev == 3) begin
         m_phase = 0;
      end else if (m_phase == 0) begin
         m_hold = d; m_phase = 1;
      end else begin
         m_phase = 0;
         if (!(zero && prev >= 1)) begin
            q_word.push_back({r, m_hold, d});
            q_due.push_back(cyc + 3);
         end
      end
      repeat (5) @(negedge clk);
   endtask

   task automatic bus_read();
      @(negedge clk);
      rd_n = 1'b0;
      m_db_next = (m_phase == 0) ? rd_word[17:9] : rd_word[8:0];
      m_db_due = cyc + 3;
      repeat (2) @(negedge clk);
      rd_n = 1'b1;
      m_phase = 1 - m_phase;
      repeat (5) @(negedge clk);
   endtask

   task automatic sync4();
      for (int i = 0; i < 4; i++) bus_write(1'b0, 9'd0);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      cur_req = "R1";
      check("R1", {31'd0, word_valid}, 32'd0, "reset word_valid");
      check("R1", {23'd0, db_out}, 32'd0, "reset db_out");
      rst_n = 1'b1;
      @(negedge clk);
      checking = 1;
      // R1: first write after reset is an upper half
      bus_write(1'b1, 9'h155);
      bus_write(1'b1, 9'h0AA);
      cur_req = "R6"; sync4();
      cur_req = "R2";
      bus_write(1'b1, 9'h1A5); bus_write(1'b1, 9'h0F3);
      bus_write(1'b0, 9'h001); bus_write(1'b0, 9'h120);
      cur_req = "R3";
      bus_write(1'b1, 9'h1FF); bus_write(1'b1, 9'h000);
      cur_req = "R4";
      rd_word = 18'h2B3C5;
      bus_read(); bus_read();
      rd_word = 18'h1E0F1;
      bus_read(); bus_read();
      cur_req = "R5";
      bus_read();
      bus_write(1'b1, 9'h03C);
      bus_write(1'b1, 9'h111); bus_write(1'b1, 9'h0EE);
      cur_req = "R6";
      bus_write(1'b1, 9'h077);          // slip: phase now lower
      sync4();
      bus_write(1'b1, 9'h18C); bus_write(1'b1, 9'h063);
      cur_req = "R7";
      bus_write(1'b0, 9'd0); bus_write(1'b0, 9'd0); bus_write(1'b0, 9'd0);
      bus_write(1'b1, 9'd0);            // data zero breaks the run
      bus_write(1'b0, 9'd0);
      bus_write(1'b0, 9'h0B2); bus_write(1'b0, 9'h1C4);
      cur_req = "R7";
      bus_write(1'b0, 9'd0); bus_write(1'b0, 9'd0);
      rd_word = 18'h3FFFF; bus_read();  // read keeps the run count
      bus_write(1'b0, 9'd0); bus_write(1'b0, 9'd0);
      bus_write(1'b1, 9'h0D5); bus_write(1'b1, 9'h12A);
      cur_req = "R8";
      bus_write(1'b0, 9'h1F0);
      sync4();
      bus_write(1'b0, 9'h00F); bus_write(1'b0, 9'h0F0);
      cur_req = "R9";
      sync4(); sync4();
      bus_write(1'b1, 9'h16D); bus_write(1'b1, 9'h092);
      cur_req = "R10";
      bus_write(1'b1, 9'h1AB);
      bus_read();
      bus_write(1'b1, 9'h054);
      repeat (6) @(negedge clk);
      check("R10", q_due.size(), 32'd0, "pending words drained");
      done = 1;
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         finish_run();
      end
   end
endmodule